// File: doc/BRIEF.md
# Prescaled 32-bit reload down-timer

This block is a 32-bit down-counting timer. Its count rate is set by a 32-bit divide value, and a 32-bit period value reloads it after it reaches zero. Software reaches it through a 16-bit register port with an address, a write enable, write data and combinational read data. Every 32-bit quantity is therefore split into a low word and a high word. A prescaler counts system clocks. Each time it passes through zero it emits a tick, and the main counter steps down by one on each tick.

When the counter steps from one to zero, the block raises a single-cycle interrupt pulse. On the next tick it reloads the counter from the period. Software has two controls in the control word. A self-clearing reload bit loads the period into the counter at once and restarts the prescaler. A stop bit freezes both the prescaler and the counter.

Top module: `tick_reload_timer`

## Requirements
- R1: After reset the registers read as follows: counter low 0xFFFF, counter high 0x0000, period low 0xFFFF, period high 0x0000, control 0x0000, divide low and divide high 0x0000. The interrupt output is low.
- R2: While running, the counter decrements by one every (D+1) clock cycles, where D is the 32-bit divide value. A borrow from the low word into the high word is carried.
- R3: Writing control with bit 5 (reload) set has two effects at that clock edge: the counter takes the period value and the prescaler restarts from D. Bit 5 always reads back as 0.
- R4: A tick that finds the counter at zero reloads it from the period. The interrupt therefore repeats every (P+1)(D+1) cycles, where P is the period.
- R5: The interrupt is high for exactly one cycle. It is high in the cycle in which the counter first reads zero after counting down from one.
- R6: Control bit 4 (stop) reads back as written. While it is 1, neither the counter nor the prescaler changes, and no interrupt is raised.
- R7: The word offsets are fixed: counter low at 0, counter high at 1, period low at 2, period high at 3, control at 4, divide low at 6, divide high at 7. Each of these reads back what was last written to it.
- R8: Offset 5 and offsets 8 to 15 always read 0. Writes to them change no register.
- R9: A bus write to a counter half takes effect at that clock edge and takes priority over counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the addressed word |
| addr | input | 4 | Word offset |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data of the addressed word (combinational) |
| irq | output | 1 | Single-cycle timer interrupt |

## Verification
The hardest case to reach is the 32-bit borrow, where the count passes from 0x0001_0000 to 0x0000_FFFF. With reset values it would take tens of thousands of cycles. The bench reaches it quickly. It stops the timer and sets the divide value to zero, so that a reload-plus-stop leaves the prescaler at zero. It then loads 0x0001_0000 directly into the counter halves and releases stop, so the very next edge performs the borrow. The interrupt spacing is measured over two full reload periods with a small period and divide value, because the reload on the tick after zero shows only on the second pulse.

// File: rtl/tick_reload_timer.sv
module tick_reload_timer #(
  parameter int WORD_W     = 16,
  parameter int ADDR_W     = 4,
  parameter int STOP_BIT   = 4,
  parameter int RELOAD_BIT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  output logic              irq
);
  localparam int CNT_W = 2 * WORD_W;
  localparam logic [ADDR_W-1:0] OFS_CNT_LO = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_CNT_HI = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] OFS_PER_LO = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] OFS_PER_HI = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] OFS_CTRL   = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFS_DIV_LO = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] OFS_DIV_HI = ADDR_W'(7);
  localparam logic [CNT_W-1:0]  RST_WORD   = CNT_W'({WORD_W{1'b1}});

  logic [CNT_W-1:0] cnt_q, per_q, div_q, psc_q;
  logic             stop_q;

  logic sel_cnt_lo, sel_cnt_hi, sel_ctrl, cnt_wr, reload, tick;

  assign sel_cnt_lo = wr_en && addr == OFS_CNT_LO;
  assign sel_cnt_hi = wr_en && addr == OFS_CNT_HI;
  assign sel_ctrl   = wr_en && addr == OFS_CTRL;
  assign cnt_wr     = sel_cnt_lo || sel_cnt_hi;
  assign reload     = sel_ctrl && wr_data[RELOAD_BIT];
  assign tick       = !stop_q && psc_q == '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_q  <= RST_WORD;
      div_q  <= '0;
      stop_q <= 1'b0;
    end else if (wr_en) begin
      case (addr)
        OFS_PER_LO: per_q[WORD_W-1:0]     <= wr_data;
        OFS_PER_HI: per_q[CNT_W-1:WORD_W] <= wr_data;
        OFS_DIV_LO: div_q[WORD_W-1:0]     <= wr_data;
        OFS_DIV_HI: div_q[CNT_W-1:WORD_W] <= wr_data;
        OFS_CTRL:   stop_q                <= wr_data[STOP_BIT];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      psc_q <= '0;
    else if (reload || tick)
      psc_q <= div_q;
    else if (!stop_q)
      psc_q <= psc_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= RST_WORD;
    end else if (cnt_wr) begin
      if (sel_cnt_lo) cnt_q[WORD_W-1:0]     <= wr_data;
      if (sel_cnt_hi) cnt_q[CNT_W-1:WORD_W] <= wr_data;
    end else if (reload) begin
      cnt_q <= per_q;
    end else if (tick) begin
      cnt_q <= (cnt_q == '0) ? per_q : cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= tick && cnt_q == CNT_W'(1) && !cnt_wr && !reload;
  end

  always_comb begin
    rd_data = '0;
    case (addr)
      OFS_CNT_LO: rd_data = cnt_q[WORD_W-1:0];
      OFS_CNT_HI: rd_data = cnt_q[CNT_W-1:WORD_W];
      OFS_PER_LO: rd_data = per_q[WORD_W-1:0];
      OFS_PER_HI: rd_data = per_q[CNT_W-1:WORD_W];
      OFS_CTRL:   rd_data[STOP_BIT] = stop_q;
      OFS_DIV_LO: rd_data = div_q[WORD_W-1:0];
      OFS_DIV_HI: rd_data = div_q[CNT_W-1:WORD_W];
      default:    rd_data = '0;
    endcase
  end
endmodule

// File: rtl/tick_reload_timer_chk.sv
module tick_reload_timer_chk #(
  parameter int WORD_W     = 16,
  parameter int ADDR_W     = 4,
  parameter int STOP_BIT   = 4,
  parameter int RELOAD_BIT = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic [ADDR_W-1:0]     addr,
  input logic [WORD_W-1:0]     wr_data,
  input logic [WORD_W-1:0]     rd_data,
  input logic                  irq,
  input logic [2*WORD_W-1:0]   cnt,
  input logic [2*WORD_W-1:0]   per,
  input logic                  stop,
  input logic                  tick
);
  localparam int CNT_W = 2 * WORD_W;
  logic bus_touch;
  assign bus_touch = wr_en && (addr == ADDR_W'(0) || addr == ADDR_W'(1) ||
                     (addr == ADDR_W'(4) && wr_data[RELOAD_BIT]));

  a_r2_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt != '0 && !bus_touch) |=> cnt == $past(cnt) - CNT_W'(1));

  a_r3_reload_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(4) && wr_data[RELOAD_BIT]) |=> cnt == $past(per));

  a_r4_zero_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == '0 && !bus_touch) |=> cnt == $past(per));

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  a_r5_irq_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> cnt == '0);

  a_r6_stop_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !wr_en) |=> $stable(cnt) && !irq);

  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(5) || addr > ADDR_W'(7)) |-> rd_data == '0);
endmodule

bind tick_reload_timer tick_reload_timer_chk #(
  .WORD_W(WORD_W), .ADDR_W(ADDR_W), .STOP_BIT(STOP_BIT), .RELOAD_BIT(RELOAD_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .rd_data(rd_data), .irq(irq), .cnt(cnt_q), .per(per_q), .stop(stop_q),
  .tick(tick)
);

// File: tb/tick_reload_timer_bench.sv
`timescale 1ns/1ps
module tick_reload_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tick_reload_timer u_tick_reload_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  // {write, addr, data, expected readback}
  localparam int NV = 15;
  localparam logic [36:0] VEC [NV] = '{
    {1'b1, 4'd4, 16'h0010, 16'h0010},  // R6 stop reads back
    {1'b1, 4'd0, 16'h0005, 16'h0005},  // R7 R9
    {1'b1, 4'd1, 16'h0002, 16'h0002},  // R7 R9
    {1'b1, 4'd2, 16'h1234, 16'h1234},  // R7
    {1'b1, 4'd3, 16'hABCD, 16'hABCD},  // R7
    {1'b1, 4'd6, 16'h0003, 16'h0003},  // R7
    {1'b1, 4'd7, 16'h0001, 16'h0001},  // R7
    {1'b1, 4'd5, 16'hFFFF, 16'h0000},  // R8
    {1'b0, 4'd4, 16'h0000, 16'h0010},  // R8 neighbour intact
    {1'b0, 4'd6, 16'h0000, 16'h0003},  // R8 neighbour intact
    {1'b1, 4'd9, 16'h5555, 16'h0000},  // R8
    {1'b0, 4'd0, 16'h0000, 16'h0005},  // R6 frozen
    {1'b1, 4'd4, 16'h0030, 16'h0010},  // R3 reload bit reads 0
    {1'b0, 4'd0, 16'h0000, 16'h1234},  // R3
    {1'b0, 4'd1, 16'h0000, 16'hABCD}   // R3
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    addr = a;
    #0.5;
    d = rd_data;
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, v2;
    int first_irq, second_irq, pulses;
    bit irq_seen;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    rd(4'd0, v); chk("R1 cnt lo", v, 16'hFFFF);
    rd(4'd1, v); chk("R1 cnt hi", v, 16'h0000);
    rd(4'd2, v); chk("R1 per lo", v, 16'hFFFF);
    rd(4'd3, v); chk("R1 per hi", v, 16'h0000);
    rd(4'd4, v); chk("R1 ctrl", v, 16'h0000);
    rd(4'd6, v); chk("R1 div lo", v, 16'h0000);
    rd(4'd7, v); chk("R1 div hi", v, 16'h0000);
    chk("R1 irq", irq, 1'b0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][36]) wr(VEC[i][35:32], VEC[i][31:16]);
      rd(VEC[i][35:32], v);
      chk($sformatf("R7/R8 vector %0d", i), v, VEC[i][15:0]);
    end

    // R2 R4 R5: period 4, divide 2
    wr(4'd2, 16'd4); wr(4'd3, 16'd0);
    wr(4'd6, 16'd2); wr(4'd7, 16'd0);
    wr(4'd4, 16'h0030);
    wr(4'd4, 16'h0000);
    first_irq = 0; second_irq = 0; pulses = 0;
    addr = 4'd0;
    for (int i = 1; i <= 30; i++) begin
      @(negedge clk);
      #0.5;
      if (i == 2) chk("R2 count holds before tick", rd_data, 16'd4);
      if (i == 3) chk("R2 count after D+1 cycles", rd_data, 16'd3);
      if (irq) begin
        pulses++;
        if (first_irq == 0) first_irq = i; else if (second_irq == 0) second_irq = i;
        chk("R5 counter zero with irq", rd_data, 16'd0);
      end
      if (i == 15) chk("R4 reload on tick after zero", rd_data, 16'd4);
    end
    chk("R5 first irq cycle", first_irq, 12);
    chk("R4 irq spacing (P+1)(D+1)", second_irq - first_irq, 15);
    chk("R5 one cycle per pulse", pulses, 2);

    // R6 stop freezes
    wr(4'd4, 16'h0010);
    rd(4'd0, v);
    irq_seen = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (irq) irq_seen = 1'b1;
    end
    rd(4'd0, v2);
    chk("R6 counter frozen", v2, v);
    chk("R6 no irq while stopped", irq_seen, 1'b0);

    // R2 R9 borrow across halves with divide 0
    wr(4'd6, 16'd0);
    wr(4'd4, 16'h0030);
    wr(4'd0, 16'h0000);
    wr(4'd1, 16'h0001);
    rd(4'd0, v); chk("R9 written lo", v, 16'h0000);
    rd(4'd1, v); chk("R9 written hi", v, 16'h0001);
    wr(4'd4, 16'h0000);
    @(negedge clk);
    rd(4'd0, v); chk("R2 borrow lo", v, 16'hFFFF);
    rd(4'd1, v); chk("R2 borrow hi", v, 16'h0000);
    @(negedge clk);
    rd(4'd0, v); chk("R2 next decrement", v, 16'hFFFE);

    // R3 reload while running
    wr(4'd4, 16'h0020);
    rd(4'd0, v); chk("R3 immediate reload lo", v, 16'd4);
    rd(4'd1, v); chk("R3 immediate reload hi", v, 16'd0);
    rd(4'd4, v); chk("R3 ctrl reads zero", v, 16'h0000);
    @(negedge clk);
    rd(4'd0, v); chk("R3 counting resumes", v, 16'd3);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule